// File: doc/BRIEF.md
# Dimension-Order Route Computation Unit

This block is the route computation stage for one input port of a router in a two-dimensional network. On a header strobe it compares the packet's destination coordinates with the coordinates of the local node. It then requests exactly one output: the west, east, south or north neighbour, or the local processor port. The X offset is always reduced to zero before any Y hop is taken. A packet therefore moves along X, turns at most once, and then moves along Y.

A mode input selects mesh or torus operation. In mesh mode the direction follows the sign of each offset. In torus mode each dimension is a ring, and the unit takes the shorter way round. When both ways are equal, it takes the positive way. Plain dimension order can deadlock on a ring, so the unit also picks one of two virtual channels for the next hop.

A packet uses channel 0 until it crosses the wraparound link of its current dimension, and channel 1 after that. The channel returns to 0 when the packet turns from X into Y. The channel the packet arrived on, and whether it arrived over an X link, are inputs. The decision is registered and appears one cycle after the strobe.

Top module: `dor_route_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first header, route_valid, route_port and route_vc are all 0.
- R2: route_valid is high exactly in the cycle after a cycle in which hdr_valid was sampled high. When route_valid is low, route_port and route_vc are 0.
- R3: In mesh mode (torus_mode=0), with dst_x different from node_x, the port is west (route_port bit 0) when dst_x < node_x and east (bit 1) when dst_x > node_x.
- R4: In mesh mode, with dst_x = node_x, the port is south (bit 2) when dst_y < node_y and north (bit 3) when dst_y > node_y.
- R5: When dst_x = node_x and dst_y = node_y, the port is local (bit 4) and route_vc is 0, in either mode.
- R6: Whenever route_valid is high, exactly one bit of route_port is set.
- R7: In torus mode, X is still resolved before Y. Each dimension takes the positive way (east or north) when the forward distance (dst - node) mod 16 is at most 16 minus that distance; otherwise it takes the negative way. A distance of exactly 8 therefore goes positive.
- R8: In torus mode, route_vc is 1 when the chosen hop crosses the wraparound link: a positive hop from coordinate 15, or a negative hop from coordinate 0.
- R9: In torus mode, for a hop that does not cross the wraparound link, route_vc follows these rules. An X hop copies in_vc when in_x_hop=1, and is 0 otherwise. A Y hop is 0 when in_x_hop=1, because that hop is a turn. A Y hop copies in_vc when in_x_hop=0, meaning the packet arrived on a Y link or, with in_vc=0, from the local port.
- R10: In mesh mode, route_vc is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| dst_x | input | 4 | Destination X coordinate |
| dst_y | input | 4 | Destination Y coordinate |
| node_x | input | 4 | Local node X coordinate |
| node_y | input | 4 | Local node Y coordinate |
| torus_mode | input | 1 | 1 = torus rings, 0 = mesh |
| in_x_hop | input | 1 | Packet arrived over an X-dimension link |
| in_vc | input | 1 | Virtual channel the packet arrived on |
| route_valid | output | 1 | Registered decision valid |
| route_port | output | 5 | One-hot port: bit0 W, bit1 E, bit2 S, bit3 N, bit4 L |
| route_vc | output | 1 | Virtual channel for the next hop |

## Verification
Direction choice and virtual-channel choice fall in the same cycle when a torus hop crosses the wraparound link. In that case the port and route_vc must both change together: for example, node 15 going east with route_vc 1. The same holds for a turn into Y, where in_vc=1 must be overridden to 0 at the very cycle the port switches from X to Y. Directed headers place the node at coordinates 0 and 15, and at exact half-ring distances, with each combination of arriving channel and arrival dimension. Random headers follow, and each is compared in the next cycle against a behavioural model.

// File: rtl/dor_pkg.sv
package dor_pkg;
    localparam int NUM_PORTS = 5;
    localparam int P_WEST    = 0;
    localparam int P_EAST    = 1;
    localparam int P_SOUTH   = 2;
    localparam int P_NORTH   = 3;
    localparam int P_LOCAL   = 4;
    localparam int NUM_DIMS  = 2;
    localparam int DIM_X     = 0;
    localparam int DIM_Y     = 1;

    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] port;
        logic                 vc;
    } route_state_t;
endpackage

// File: rtl/dor_axis_step.sv
module dor_axis_step #(
    parameter int W     = 4,
    parameter int RADIX = 16
) (
    input  logic [W-1:0] loc,
    input  logic [W-1:0] dst,
    input  logic         torus,
    output logic         move,
    output logic         pos,
    output logic         wrap
);
    localparam logic [W:0]   RAD_V   = (W+1)'(RADIX);
    localparam logic [W-1:0] LAST_IX = W'(RADIX - 1);

    logic [W:0] fwd;
    logic [W:0] back;

    always_comb begin
        if (dst >= loc) begin
            fwd = {1'b0, dst} - {1'b0, loc};
        end else begin
            fwd = {1'b0, dst} + RAD_V - {1'b0, loc};
        end
        back = RAD_V - fwd;
        move = (dst != loc);
        if (torus) begin
            pos  = (fwd <= back);
            wrap = move && (pos ? (loc == LAST_IX) : (loc == '0));
        end else begin
            pos  = (dst > loc);
            wrap = 1'b0;
        end
    end
endmodule

// File: rtl/dor_vc_pick.sv
module dor_vc_pick (
    input  logic torus,
    input  logic x_move,
    input  logic y_move,
    input  logic x_wrap,
    input  logic y_wrap,
    input  logic in_x_hop,
    input  logic in_vc,
    output logic vc
);
    always_comb begin
        vc = 1'b0;
        if (torus) begin
            if (x_move) begin
                vc = x_wrap | (in_x_hop & in_vc);
            end else if (y_move) begin
                vc = y_wrap | (~in_x_hop & in_vc);
            end
        end
    end
endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
    import dor_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int RADIX_X = 16,
    parameter int RADIX_Y = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  logic [COORD_W-1:0]   dst_x,
    input  logic [COORD_W-1:0]   dst_y,
    input  logic [COORD_W-1:0]   node_x,
    input  logic [COORD_W-1:0]   node_y,
    input  logic                 torus_mode,
    input  logic                 in_x_hop,
    input  logic                 in_vc,
    output logic                 route_valid,
    output logic [NUM_PORTS-1:0] route_port,
    output logic                 route_vc
);
    logic [NUM_DIMS-1:0][COORD_W-1:0] loc_a;
    logic [NUM_DIMS-1:0][COORD_W-1:0] dst_a;
    logic [NUM_DIMS-1:0]              move_a;
    logic [NUM_DIMS-1:0]              pos_a;
    logic [NUM_DIMS-1:0]              wrap_a;
    logic                             vc_pick;

    assign loc_a[DIM_X] = node_x;
    assign loc_a[DIM_Y] = node_y;
    assign dst_a[DIM_X] = dst_x;
    assign dst_a[DIM_Y] = dst_y;

    for (genvar g = 0; g < NUM_DIMS; g++) begin : g_axis
        localparam int RAD = (g == DIM_X) ? RADIX_X : RADIX_Y;
        dor_axis_step #(
            .W     (COORD_W),
            .RADIX (RAD)
        ) u_axis (
            .loc   (loc_a[g]),
            .dst   (dst_a[g]),
            .torus (torus_mode),
            .move  (move_a[g]),
            .pos   (pos_a[g]),
            .wrap  (wrap_a[g])
        );
    end

    dor_vc_pick u_vc (
        .torus    (torus_mode),
        .x_move   (move_a[DIM_X]),
        .y_move   (move_a[DIM_Y]),
        .x_wrap   (wrap_a[DIM_X]),
        .y_wrap   (wrap_a[DIM_Y]),
        .in_x_hop (in_x_hop),
        .in_vc    (in_vc),
        .vc       (vc_pick)
    );

    route_state_t st_d;
    route_state_t st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = hdr_valid;
        if (hdr_valid) begin
            if (move_a[DIM_X]) begin
                st_d.port[pos_a[DIM_X] ? P_EAST : P_WEST] = 1'b1;
            end else if (move_a[DIM_Y]) begin
                st_d.port[pos_a[DIM_Y] ? P_NORTH : P_SOUTH] = 1'b1;
            end else begin
                st_d.port[P_LOCAL] = 1'b1;
            end
            st_d.vc = vc_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_valid = st_q.valid;
    assign route_port  = st_q.port;
    assign route_vc    = st_q.vc;
endmodule

// File: rtl/dor_route_chk.sv
module dor_route_chk #(
    parameter int COORD_W = 4,
    parameter int RADIX_X = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_valid,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic [COORD_W-1:0] node_x,
    input logic [COORD_W-1:0] node_y,
    input logic               torus_mode,
    input logic               route_valid,
    input logic [4:0]         route_port,
    input logic               route_vc
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> route_valid);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> (route_port == 5'd0 && !route_vc));

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> ($countones(route_port) == 1));

    a_r3_mesh_west: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !torus_mode && dst_x < node_x) |=> route_port[0]);

    a_r4_mesh_north: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !torus_mode && dst_x == node_x && dst_y > node_y) |=> route_port[3]);

    a_r5_local: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dst_x == node_x && dst_y == node_y) |=> (route_port[4] && !route_vc));

    a_r8_east_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && torus_mode && node_x == COORD_W'(RADIX_X - 1) && dst_x == '0)
        |=> (route_port[1] && route_vc));

    a_r10_mesh_vc0: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !torus_mode) |=> !route_vc);
endmodule

bind dor_route_unit dor_route_chk #(.COORD_W(COORD_W), .RADIX_X(RADIX_X)) u_chk (.*);

// File: tb/tb_dor_route_unit.sv
`timescale 1ns/1ps
module tb_dor_route_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_valid = 1'b0;
    logic [3:0] dst_x = '0, dst_y = '0, node_x = '0, node_y = '0;
    logic       torus_mode = 1'b0, in_x_hop = 1'b0, in_vc = 1'b0;
    logic       route_valid;
    logic [4:0] route_port;
    logic       route_vc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_valid = 0, exp_port = 0, exp_vc = 0;
    string port_tag = "R2", vc_tag = "R2";

    always #2 clk = ~clk;

    dor_route_unit dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
        .dst_x(dst_x), .dst_y(dst_y), .node_x(node_x), .node_y(node_y),
        .torus_mode(torus_mode), .in_x_hop(in_x_hop), .in_vc(in_vc),
        .route_valid(route_valid), .route_port(route_port), .route_vc(route_vc)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one axis decision: returns dir (+1/-1/0) and whether the hop wraps
    task automatic axis(int n, int d, int t, output int dir, output int wr);
        int f;
        wr = 0;
        if (n == d) dir = 0;
        else if (t == 0) dir = (d > n) ? 1 : -1;
        else begin
            f = (d - n + 16) % 16;
            dir = (f <= 16 - f) ? 1 : -1;
            wr = (dir == 1) ? (n == 15) : (n == 0);
        end
    endtask

    task automatic model(int nx, int ny, int dx, int dy, int t, int ix, int iv);
        int xd, xw, yd, yw;
        axis(nx, dx, t, xd, xw);
        axis(ny, dy, t, yd, yw);
        if (xd != 0) begin
            exp_port = (xd > 0) ? 2 : 1;
            port_tag = t ? "R7" : "R3";
            exp_vc   = t ? (xw ? 1 : (ix ? iv : 0)) : 0;
        end else if (yd != 0) begin
            exp_port = (yd > 0) ? 8 : 4;
            port_tag = t ? "R7" : "R4";
            exp_vc   = t ? (yw ? 1 : (ix ? 0 : iv)) : 0;
        end else begin
            exp_port = 16;
            port_tag = "R5";
            exp_vc   = 0;
        end
        if (exp_port == 16) vc_tag = "R5";
        else if (!t) vc_tag = "R10";
        else if (xw || (xd == 0 && yw)) vc_tag = "R8";
        else vc_tag = "R9";
    endtask

    task automatic compare();
        check("R2 valid", route_valid, exp_valid);
        if (exp_valid != 0) begin
            check({port_tag, " port"}, route_port, exp_port);
            check({vc_tag, " vc"}, route_vc, exp_vc);
            check("R6 onehot", $countones(route_port), 1);
        end else begin
            check("R2 idle port", route_port, 0);
            check("R2 idle vc", route_vc, 0);
        end
    endtask

    task automatic step(int v, int nx, int ny, int dx, int dy, int t, int ix, int iv);
        @(negedge clk);
        compare();
        hdr_valid = v[0]; node_x = nx[3:0]; node_y = ny[3:0];
        dst_x = dx[3:0]; dst_y = dy[3:0]; torus_mode = t[0];
        in_x_hop = ix[0]; in_vc = iv[0];
        exp_valid = v;
        if (v != 0) model(nx, ny, dx, dy, t, ix, iv);
    endtask

    initial begin
        hdr_valid = 1'b1; dst_x = 4'd3; node_x = 4'd9;
        repeat (3) @(negedge clk);
        check("R1 reset valid", route_valid, 0);
        check("R1 reset port", route_port, 0);
        check("R1 reset vc", route_vc, 0);
        hdr_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post valid", route_valid, 0);
        check("R1 post port", route_port, 0);
        // mesh directions
        step(1, 5, 5, 2, 9, 0, 1, 1);   // R3 west, R10 vc0
        step(1, 5, 5, 11, 0, 0, 0, 1);  // R3 east
        step(1, 5, 5, 5, 1, 0, 1, 1);   // R4 south
        step(1, 5, 5, 5, 14, 0, 0, 1);  // R4 north
        step(1, 5, 5, 5, 5, 0, 1, 1);   // R5 local
        step(0, 5, 5, 2, 2, 1, 1, 1);   // R2 idle with busy inputs
        step(1, 0, 0, 15, 0, 0, 0, 0);  // R3 mesh no wrap
        // torus shortest way and ties
        step(1, 0, 4, 8, 4, 1, 0, 0);   // R7 tie goes east
        step(1, 3, 4, 11, 4, 1, 1, 1);  // R7 tie east, R9 keep vc
        step(1, 3, 4, 12, 4, 1, 1, 1);  // R7 west, R9 keep
        step(1, 6, 6, 6, 14, 1, 0, 0);  // R7 tie north
        step(1, 6, 6, 6, 15, 1, 0, 0);  // R7 south
        // wraparound and channel rules
        step(1, 15, 2, 2, 2, 1, 0, 0);  // R8 east wrap
        step(1, 0, 2, 14, 9, 1, 1, 0);  // R8 west wrap
        step(1, 7, 15, 7, 1, 1, 1, 0);  // R8 north wrap on turn
        step(1, 7, 0, 7, 13, 1, 0, 0);  // R8 south wrap
        step(1, 7, 3, 7, 5, 1, 1, 1);   // R9 turn resets to vc0
        step(1, 7, 3, 7, 5, 1, 0, 1);   // R9 Y continue keeps vc1
        step(1, 4, 3, 6, 5, 1, 0, 1);   // R9 X from local -> vc0
        step(1, 9, 9, 9, 9, 1, 1, 1);   // R5 local torus vc0
        step(1, 15, 0, 0, 0, 0, 1, 1);  // R10 mesh vc0, R3
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 5) != 0, $urandom % 16, $urandom % 16,
                 $urandom % 16, $urandom % 16, $urandom % 2,
                 $urandom % 2, $urandom % 2);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule